// File: doc/BRIEF.md
# Memory Ordering Group Dispatcher

This block sits at the dispatch stage of an out-of-order core model and sorts memory operations into ordering groups. Each dispatched operation carries three flags: it reads memory, it writes memory, or it is a barrier with side effects. Any mix of these flags is allowed. In the same cycle the block answers with a group ID and up to three predecessor-group edges. A downstream scheduler uses those edges to hold the new group until its predecessors have run. Plain loads that have no store or barrier between them share one group, so they may run in any order relative to each other. Stores and barriers always open a fresh group.

The block also counts occupancy in a load queue and a store queue. Before it accepts an operation, it reports whether the operation can go or which queue blocks it. Retire events return queue slots. An issue-start event marks a group as executing, so later loads can no longer join it. A group-finished event removes the group's ID from every register that tracks the most recent group of each kind. A no-alias input relaxes the ordering edges that exist only because addresses might overlap.

Top module: `mem_order_dispatch`

## Requirements
- R1: Group IDs count up from 1. The first group opened after reset is 1. After the largest value of the GID_W-bit counter, the next group opened is 1 again, so 0 is never issued. A dispatch that is not accepted drives 0 on `disp_gid`.
- R2: Every accepted operation with the write flag set opens a new group (`disp_new` = 1). Its slot-0 edge names D, the larger of the last load group and the last load-barrier group. The edge is present when D is nonzero and either `no_alias` is 0 or D equals the last load-barrier group.
- R3: A write also gets a slot-1 edge to the last store-barrier group whenever that group is nonzero. It gets a slot-2 edge to the last store group when that group is nonzero, differs from the last store-barrier group, and `no_alias` is 0.
- R4: A read-only operation opens a new group when any of the following holds: it is a barrier; D is 0; D equals the last load-barrier group; D is not greater than the last store group; or group D has started executing.
- R5: A new read-only group gets a slot-2 edge to the last store group when that group is nonzero and `no_alias` is 0. Its slot-0 edge names D if it is a barrier, or the last load-barrier group if it is not. Either slot-0 edge is present only when the named ID is nonzero.
- R6: A read-only operation that opens no new group joins the last load group. It returns that group's ID with `disp_new` = 0 and no edges.
- R7: `avail_status` is 1 when the read flag is set and the load queue is full. Otherwise it is 2 when the write flag is set and the store queue is full. Otherwise it is 0. The status is computed from the flags in the same cycle.
- R8: An accepted operation takes one load-queue slot if it reads and one store-queue slot if it writes. A retire event gives back the slots it names. A dispatch that is refused changes no queue count and no group register, and it drives no edges.
- R9: A group-finished event sets to 0 every tracking register (last load, last store, last load-barrier, last store-barrier) that holds the finished ID.
- R10: An issue-start event marks a group as executing. A later plain load whose D is that group then opens a new group instead of joining it.
- R11: A barrier that both reads and writes sets all four tracking registers to its new ID in the cycle it is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| no_alias | input | 1 | Drop edges that exist only because addresses might overlap |
| disp_valid | input | 1 | Dispatch request |
| disp_rd | input | 1 | Operation reads memory |
| disp_wr | input | 1 | Operation writes memory |
| disp_bar | input | 1 | Operation is a barrier |
| avail_status | output | 2 | 0 go, 1 load queue full, 2 store queue full |
| disp_gid | output | GID_W | Group ID assigned to the accepted operation |
| disp_new | output | 1 | Accepted operation opened a new group |
| e0_valid | output | 1 | Slot-0 edge (load-side predecessor) present |
| e0_gid | output | GID_W | Slot-0 predecessor group |
| e1_valid | output | 1 | Slot-1 edge (store-barrier predecessor) present |
| e1_gid | output | GID_W | Slot-1 predecessor group |
| e2_valid | output | 1 | Slot-2 edge (store predecessor) present |
| e2_gid | output | GID_W | Slot-2 predecessor group |
| issue_valid | input | 1 | A group has started executing |
| issue_gid | input | GID_W | Group that started |
| done_valid | input | 1 | A group has finished executing |
| done_gid | input | GID_W | Group that finished |
| ret_valid | input | 1 | Retire event |
| ret_rd | input | 1 | Retired operation held a load-queue slot |
| ret_wr | input | 1 | Retired operation held a store-queue slot |

## Verification
The hardest case to reach is a plain load whose dominating group is neither a barrier nor older than the last store, but has already started executing. Only the executing bit then decides between joining and opening a group. The bench builds this case in three steps. It dispatches two plain loads under no-alias so that they share one group. It then raises an issue-start event for that group. Finally it dispatches a third load. The bench also runs a long pseudo-random mix of dispatch, issue, finish and retire events. That mix uses 3-bit IDs and two-entry queues, so ID wrap-around and full-queue refusals happen often. A reference model in the bench predicts every output.

// File: rtl/mo_pkg.sv
package mo_pkg;

    typedef enum logic [1:0] {
        AV_GO      = 2'd0,
        AV_LQ_FULL = 2'd1,
        AV_SQ_FULL = 2'd2
    } avail_e;

    typedef struct packed {
        logic rd;
        logic wr;
        logic bar;
    } op_flags_t;

    function automatic avail_e avail_of(op_flags_t f, logic lq_full, logic sq_full);
        if (f.rd && lq_full)      return AV_LQ_FULL;
        else if (f.wr && sq_full) return AV_SQ_FULL;
        else                      return AV_GO;
    endfunction

endpackage

// File: rtl/mo_occupancy.sv
module mo_occupancy #(
    parameter int DEPTH = 4,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          take,
    input  logic          give,
    output logic          full,
    output logic [CW-1:0] count
);
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else begin
            case ({take, give})
                2'b10:   cnt_q <= cnt_q + CW'(1);
                2'b01:   if (cnt_q != '0) cnt_q <= cnt_q - CW'(1);
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    assign full  = (cnt_q == CW'(DEPTH));
    assign count = cnt_q;
endmodule

// File: rtl/mo_group_table.sv
module mo_group_table #(
    parameter int GID_W = 4,
    localparam int NG = 1 << GID_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             alloc,
    output logic [GID_W-1:0] next_gid,
    input  logic             issue_valid,
    input  logic [GID_W-1:0] issue_gid,
    input  logic [GID_W-1:0] query_gid,
    output logic             query_exec
);
    logic [NG-1:0]    exec_q;
    logic [GID_W-1:0] next_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            next_q <= GID_W'(1);
        end else if (alloc) begin
            next_q <= (next_q == {GID_W{1'b1}}) ? GID_W'(1) : next_q + GID_W'(1);
        end
    end

    for (genvar g = 0; g < NG; g++) begin : g_exec
        always_ff @(posedge clk) begin
            if (rst) begin
                exec_q[g] <= 1'b0;
            end else if (alloc && next_q == GID_W'(g)) begin
                exec_q[g] <= 1'b0;
            end else if (issue_valid && issue_gid == GID_W'(g)) begin
                exec_q[g] <= 1'b1;
            end
        end
    end

    assign next_gid   = next_q;
    assign query_exec = exec_q[query_gid];
endmodule

// File: rtl/mo_dep_logic.sv
module mo_dep_logic
    import mo_pkg::*;
#(
    parameter int GID_W = 4
) (
    input  op_flags_t        op,
    input  logic             no_alias,
    input  logic [GID_W-1:0] cur_ld,
    input  logic [GID_W-1:0] cur_st,
    input  logic [GID_W-1:0] cur_lb,
    input  logic [GID_W-1:0] cur_sb,
    input  logic [GID_W-1:0] dom,
    input  logic             dom_exec,
    input  logic [GID_W-1:0] new_gid,
    output logic             open_new,
    output logic [GID_W-1:0] gid,
    output logic             e0_v,
    output logic [GID_W-1:0] e0_g,
    output logic             e1_v,
    output logic [GID_W-1:0] e1_g,
    output logic             e2_v,
    output logic [GID_W-1:0] e2_g
);
    logic dom_nz, lb_nz, st_nz, sb_nz;

    always_comb begin
        dom_nz = (dom != '0);
        lb_nz  = (cur_lb != '0);
        st_nz  = (cur_st != '0);
        sb_nz  = (cur_sb != '0);
        e0_v = 1'b0; e0_g = '0;
        e1_v = 1'b0; e1_g = '0;
        e2_v = 1'b0; e2_g = '0;
        if (op.wr) begin
            open_new = 1'b1;
            e0_v = dom_nz && (!no_alias || dom == cur_lb);
            e0_g = dom;
            e1_v = sb_nz;
            e1_g = cur_sb;
            e2_v = st_nz && (cur_st != cur_sb) && !no_alias;
            e2_g = cur_st;
        end else begin
            open_new = op.bar || !dom_nz || (dom == cur_lb) ||
                       (dom <= cur_st) || dom_exec;
            if (open_new) begin
                e2_v = st_nz && !no_alias;
                e2_g = cur_st;
                if (op.bar) begin
                    e0_v = dom_nz;
                    e0_g = dom;
                end else begin
                    e0_v = lb_nz;
                    e0_g = cur_lb;
                end
            end
        end
        gid = open_new ? new_gid : cur_ld;
    end
endmodule

// File: rtl/mem_order_dispatch.sv
module mem_order_dispatch
    import mo_pkg::*;
#(
    parameter int GID_W    = 4,
    parameter int LQ_DEPTH = 4,
    parameter int SQ_DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             no_alias,
    input  logic             disp_valid,
    input  logic             disp_rd,
    input  logic             disp_wr,
    input  logic             disp_bar,
    output logic [1:0]       avail_status,
    output logic [GID_W-1:0] disp_gid,
    output logic             disp_new,
    output logic             e0_valid,
    output logic [GID_W-1:0] e0_gid,
    output logic             e1_valid,
    output logic [GID_W-1:0] e1_gid,
    output logic             e2_valid,
    output logic [GID_W-1:0] e2_gid,
    input  logic             issue_valid,
    input  logic [GID_W-1:0] issue_gid,
    input  logic             done_valid,
    input  logic [GID_W-1:0] done_gid,
    input  logic             ret_valid,
    input  logic             ret_rd,
    input  logic             ret_wr
);
    localparam int LCW = $clog2(LQ_DEPTH + 1);
    localparam int SCW = $clog2(SQ_DEPTH + 1);

    op_flags_t        op;
    avail_e           status;
    logic             lq_full, sq_full, fire, alloc;
    logic [LCW-1:0]   lq_cnt;
    logic [SCW-1:0]   sq_cnt;
    logic [GID_W-1:0] cur_ld, cur_st, cur_lb, cur_sb, dom, new_gid, gid;
    logic             dom_exec, open_new;
    logic             d0_v, d1_v, d2_v;
    logic [GID_W-1:0] d0_g, d1_g, d2_g;

    assign op     = '{rd: disp_rd, wr: disp_wr, bar: disp_bar};
    assign status = avail_of(op, lq_full, sq_full);
    assign fire   = disp_valid && (disp_rd || disp_wr) && (status == AV_GO);
    assign alloc  = fire && open_new;
    assign dom    = (cur_ld > cur_lb) ? cur_ld : cur_lb;

    mo_occupancy #(.DEPTH(LQ_DEPTH)) u_lq (
        .clk(clk), .rst(rst),
        .take(fire && disp_rd), .give(ret_valid && ret_rd),
        .full(lq_full), .count(lq_cnt)
    );

    mo_occupancy #(.DEPTH(SQ_DEPTH)) u_sq (
        .clk(clk), .rst(rst),
        .take(fire && disp_wr), .give(ret_valid && ret_wr),
        .full(sq_full), .count(sq_cnt)
    );

    mo_group_table #(.GID_W(GID_W)) u_tbl (
        .clk(clk), .rst(rst),
        .alloc(alloc), .next_gid(new_gid),
        .issue_valid(issue_valid), .issue_gid(issue_gid),
        .query_gid(dom), .query_exec(dom_exec)
    );

    mo_dep_logic #(.GID_W(GID_W)) u_dep (
        .op(op), .no_alias(no_alias),
        .cur_ld(cur_ld), .cur_st(cur_st), .cur_lb(cur_lb), .cur_sb(cur_sb),
        .dom(dom), .dom_exec(dom_exec), .new_gid(new_gid),
        .open_new(open_new), .gid(gid),
        .e0_v(d0_v), .e0_g(d0_g), .e1_v(d1_v), .e1_g(d1_g),
        .e2_v(d2_v), .e2_g(d2_g)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_ld <= '0;
            cur_st <= '0;
            cur_lb <= '0;
            cur_sb <= '0;
        end else begin
            if (done_valid && done_gid != '0) begin
                if (cur_ld == done_gid) cur_ld <= '0;
                if (cur_st == done_gid) cur_st <= '0;
                if (cur_lb == done_gid) cur_lb <= '0;
                if (cur_sb == done_gid) cur_sb <= '0;
            end
            if (alloc) begin
                if (op.rd)           cur_ld <= new_gid;
                if (op.rd && op.bar) cur_lb <= new_gid;
                if (op.wr)           cur_st <= new_gid;
                if (op.wr && op.bar) cur_sb <= new_gid;
            end
        end
    end

    assign avail_status = status;
    assign disp_gid     = fire ? gid : '0;
    assign disp_new     = alloc;
    assign e0_valid     = fire && d0_v;
    assign e0_gid       = d0_g;
    assign e1_valid     = fire && d1_v;
    assign e1_gid       = d1_g;
    assign e2_valid     = fire && d2_v;
    assign e2_gid       = d2_g;
endmodule

// File: rtl/mo_checker.sv
module mo_checker #(
    parameter int GID_W    = 4,
    parameter int LQ_DEPTH = 4,
    localparam int LCW = $clog2(LQ_DEPTH + 1)
) (
    input logic             clk,
    input logic             rst,
    input logic             fire,
    input logic             disp_rd,
    input logic             disp_wr,
    input logic             disp_new,
    input logic [GID_W-1:0] disp_gid,
    input logic             e0_valid,
    input logic             e1_valid,
    input logic             e2_valid,
    input logic [LCW-1:0]   lq_cnt,
    input logic             ret_valid,
    input logic             ret_rd,
    input logic             done_valid,
    input logic [GID_W-1:0] done_gid,
    input logic [GID_W-1:0] cur_ld
);
    assert_gid_nonzero_R1: assert property (@(posedge clk) disable iff (rst)
        fire |-> disp_gid != '0);

    assert_write_opens_R2: assert property (@(posedge clk) disable iff (rst)
        (fire && disp_wr) |-> disp_new);

    assert_join_no_edges_R6: assert property (@(posedge clk) disable iff (rst)
        (fire && !disp_new) |-> !(e0_valid || e1_valid || e2_valid));

    assert_lq_bound_R8: assert property (@(posedge clk) disable iff (rst)
        lq_cnt <= LCW'(LQ_DEPTH));

    assert_lq_take_R8: assert property (@(posedge clk) disable iff (rst)
        (fire && disp_rd && !(ret_valid && ret_rd)) |=> lq_cnt == $past(lq_cnt) + LCW'(1));

    assert_done_clears_R9: assert property (@(posedge clk) disable iff (rst)
        (done_valid && done_gid != '0 && !disp_new) |=> cur_ld != $past(done_gid));
endmodule

bind mem_order_dispatch mo_checker #(.GID_W(GID_W), .LQ_DEPTH(LQ_DEPTH)) u_chk (
    .clk(clk), .rst(rst), .fire(fire), .disp_rd(disp_rd), .disp_wr(disp_wr),
    .disp_new(disp_new), .disp_gid(disp_gid),
    .e0_valid(e0_valid), .e1_valid(e1_valid), .e2_valid(e2_valid),
    .lq_cnt(lq_cnt), .ret_valid(ret_valid), .ret_rd(ret_rd),
    .done_valid(done_valid), .done_gid(done_gid), .cur_ld(cur_ld)
);

// File: tb/sim_mem_order_dispatch.sv
module sim_mem_order_dispatch;
    localparam int GW = 3;
    localparam int LQD = 2;
    localparam int SQD = 2;
    localparam int MAXG = (1 << GW) - 1;

    logic clk = 0, rst = 1;
    logic no_alias = 0, disp_valid = 0, disp_rd = 0, disp_wr = 0, disp_bar = 0;
    logic [1:0] avail_status;
    logic [GW-1:0] disp_gid, e0_gid, e1_gid, e2_gid;
    logic disp_new, e0_valid, e1_valid, e2_valid;
    logic issue_valid = 0, done_valid = 0, ret_valid = 0, ret_rd = 0, ret_wr = 0;
    logic [GW-1:0] issue_gid = '0, done_gid = '0;

    always #5 clk = ~clk;

    mem_order_dispatch #(.GID_W(GW), .LQ_DEPTH(LQD), .SQ_DEPTH(SQD)) u0 (
        .clk(clk), .rst(rst), .no_alias(no_alias),
        .disp_valid(disp_valid), .disp_rd(disp_rd), .disp_wr(disp_wr), .disp_bar(disp_bar),
        .avail_status(avail_status), .disp_gid(disp_gid), .disp_new(disp_new),
        .e0_valid(e0_valid), .e0_gid(e0_gid), .e1_valid(e1_valid), .e1_gid(e1_gid),
        .e2_valid(e2_valid), .e2_gid(e2_gid),
        .issue_valid(issue_valid), .issue_gid(issue_gid),
        .done_valid(done_valid), .done_gid(done_gid),
        .ret_valid(ret_valid), .ret_rd(ret_rd), .ret_wr(ret_wr)
    );

    int n_chk = 0, n_bad = 0;
    int mL = 0, mS = 0, mLB = 0, mSB = 0, mNext = 1, lq = 0, sq = 0;
    bit mExec [0:MAXG];
    int g_gid, g_new, g_e0v, g_e0g, g_e1v, g_e1g, g_e2v, g_e2g;
    logic [15:0] lfsr = 16'hACE1;

    task automatic chk(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic do_op(bit l, bit s, bit b);
        int st, dom, gid, nw, v0, g0, v1, g1, v2, g2;
        string tg, te;
        @(negedge clk);
        disp_valid = 1; disp_rd = l; disp_wr = s; disp_bar = b;
        #2;
        st = (l && lq == LQD) ? 1 : ((s && sq == SQD) ? 2 : 0);
        chk("R7 status", int'(avail_status), st);
        g_gid = int'(disp_gid); g_new = int'(disp_new);
        g_e0v = int'(e0_valid); g_e0g = int'(e0_gid);
        g_e1v = int'(e1_valid); g_e1g = int'(e1_gid);
        g_e2v = int'(e2_valid); g_e2g = int'(e2_gid);
        if (st != 0) begin
            chk("R8 refused gid", g_gid, 0);
            chk("R8 refused new", g_new, 0);
            chk("R8 refused edges", g_e0v + g_e1v + g_e2v, 0);
        end else begin
            dom = (mL > mLB) ? mL : mLB;
            v0 = 0; g0 = 0; v1 = 0; g1 = 0; v2 = 0; g2 = 0;
            if (s) begin
                tg = "R2"; te = "R3"; nw = 1; gid = mNext;
                v0 = (dom != 0 && (!no_alias || dom == mLB)); g0 = dom;
                v1 = (mSB != 0); g1 = mSB;
                v2 = (mS != 0 && mS != mSB && !no_alias); g2 = mS;
            end else begin
                nw = (b || dom == 0 || dom == mLB || dom <= mS || mExec[dom]);
                if (nw) begin
                    tg = "R4"; te = "R5"; gid = mNext;
                    v2 = (mS != 0 && !no_alias); g2 = mS;
                    if (b) begin v0 = (dom != 0); g0 = dom; end
                    else   begin v0 = (mLB != 0); g0 = mLB; end
                end else begin
                    tg = "R6"; te = "R6"; gid = mL;
                end
            end
            chk({tg, " gid"}, g_gid, gid);
            chk({tg, " new"}, g_new, nw);
            chk({tg, " e0 valid"}, g_e0v, v0);
            chk({te, " e1 valid"}, g_e1v, v1);
            chk({te, " e2 valid"}, g_e2v, v2);
            if (v0) chk({tg, " e0 gid"}, g_e0g, g0);
            if (v1) chk({te, " e1 gid"}, g_e1g, g1);
            if (v2) chk({te, " e2 gid"}, g_e2g, g2);
            if (nw) begin
                if (l) mL = gid;
                if (l && b) mLB = gid;
                if (s) mS = gid;
                if (s && b) mSB = gid;
                mExec[gid] = 0;
                mNext = (mNext == MAXG) ? 1 : mNext + 1;
            end
            if (l) lq++;
            if (s) sq++;
        end
        @(posedge clk); #1;
        disp_valid = 0; disp_rd = 0; disp_wr = 0; disp_bar = 0;
    endtask

    task automatic do_issue(int g);
        @(negedge clk); issue_valid = 1; issue_gid = GW'(g);
        @(posedge clk); #1; issue_valid = 0;
        mExec[g] = 1;
    endtask

    task automatic do_done(int g);
        @(negedge clk); done_valid = 1; done_gid = GW'(g);
        @(posedge clk); #1; done_valid = 0;
        if (g != 0) begin
            if (mL == g) mL = 0;
            if (mS == g) mS = 0;
            if (mLB == g) mLB = 0;
            if (mSB == g) mSB = 0;
        end
    endtask

    task automatic do_ret(bit l, bit s);
        @(negedge clk); ret_valid = 1; ret_rd = l; ret_wr = s;
        @(posedge clk); #1; ret_valid = 0; ret_rd = 0; ret_wr = 0;
        if (l && lq > 0) lq--;
        if (s && sq > 0) sq--;
    endtask

    function automatic logic [15:0] step(logic [15:0] v);
        return {v[14:0], v[15] ^ v[13] ^ v[12] ^ v[10]};
    endfunction

    initial begin
        for (int i = 0; i <= MAXG; i++) mExec[i] = 0;
        repeat (3) @(posedge clk);
        #1 rst = 0;
        @(negedge clk); disp_rd = 1; #2;
        chk("R7 reset status", int'(avail_status), 0);
        disp_rd = 0;

        do_op(0, 1, 0);
        chk("R1 first id", g_gid, 1);
        do_ret(0, 1);
        do_op(1, 1, 1);                       // group 2
        do_ret(1, 1);
        do_op(1, 0, 0);                       // group 3
        chk("R11 load sees load-barrier", g_e0g, 2);
        chk("R11 load sees store", g_e2g, 2);
        do_ret(1, 0);
        do_op(0, 1, 0);                       // group 4
        chk("R11 store sees store-barrier", g_e1g, 2);
        do_ret(0, 1);
        do_done(2);
        do_op(0, 1, 0);                       // group 5
        chk("R9 store-barrier cleared", g_e1v, 0);
        do_ret(0, 1);

        no_alias = 1;
        do_op(1, 0, 0);                       // group 6
        do_op(1, 0, 0);
        chk("R6 joined", g_gid, 6);
        do_ret(1, 0); do_ret(1, 0);
        do_issue(6);
        do_op(1, 0, 0);                       // group 7
        chk("R10 executing forces new", g_new, 1);
        do_ret(1, 0);
        no_alias = 0;
        do_op(0, 1, 0);
        chk("R1 wrap skips zero", g_gid, 1);
        do_ret(0, 1);

        for (int k = 0; k < 4000; k++) begin
            int a;
            lfsr = step(lfsr);
            a = int'(lfsr[3:0]);
            if (k % 500 == 0) no_alias = ~no_alias;
            if (a < 8) begin
                bit l, s;
                l = lfsr[4]; s = lfsr[5];
                if (!l && !s) l = 1;
                do_op(l, s, lfsr[6] & lfsr[7]);
            end else if (a < 10) begin
                do_issue((mL != 0 && lfsr[8]) ? mL : int'(lfsr[10:8]));
            end else if (a < 12) begin
                case (lfsr[9:8])
                    2'd0: do_done(mL);
                    2'd1: do_done(mS);
                    2'd2: do_done(mLB);
                    default: do_done(mSB);
                endcase
            end else begin
                do_ret(lfsr[4], lfsr[5]);
            end
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #2000000;
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule